// File: doc/BRIEF.md
# Radix-2 Butterfly with Shared Multipliers

This block is the arithmetic core of one stage of a streaming, pipelined FFT that uses decimation in frequency. Each cycle in which the clock enable is high, it takes two complex samples `a` and `b`, a complex twiddle factor `c` and a frame marker. Three enables later it presents two complex results: the sum `a+b`, and the difference `a-b` rotated by the twiddle. The frame marker moves down a pipeline of the same depth, so it lines up with the results of the sample pair it arrived with.

The twiddle uses fixed point, with unity equal to 2^(CF_W-2). The product is therefore scaled back by that factor. An optional extra right shift applies to both outputs, and both are rounded to the output width with round-half-to-even. The `CLK_PER_EN` parameter states how many clocks the surrounding stage guarantees from one enable to the next. The block uses that time to compute the complex product with three, two or one physical multipliers. The results are the same in every case.

The coefficient memory, the reordering buffers and the stage sequencer are outside this block. Those parts supply `a`, `b`, `c` and the frame marker already lined up.

Top module: `fft_bfly_r2`

## Requirements
- R1: After the third enable counted from the enable that accepted a pair, `res_sum` holds the rounded `a+b`, computed separately for the real and imaginary parts.
- R2: After that same enable, `res_prod` holds the rounded `(a-b)*c`, scaled down by 2^(CF_W-2): real part `dr*cr-di*ci`, imaginary part `dr*ci+di*cr`.
- R3: Samples and results are packed as {real, imag}, each half `IN_W` (inputs) or `OUT_W` (outputs) bits in two's complement. The coefficient holds its real part in the upper `CF_W` bits and its imaginary part in the lower `CF_W` bits.
- R4: Rounding to `OUT_W` drops `POST_SHIFT` fraction bits on the sum path and `CF_W-2+POST_SHIFT` fraction bits on the product path. It rounds to nearest, and an exact half goes to the even neighbour. Only the low `OUT_W` bits are kept.
- R5: Data and the frame marker each take exactly three enables from input to output. Clocks without an enable do not count toward that latency.
- R6: `sync_out` is high exactly when the results on the outputs come from a pair that was accepted with `sync_in` high. It is low otherwise, including for back-to-back marked pairs, where each result carries its own marker.
- R7: When `en` is low, the outputs and the pipeline hold their values, and changes on the data and sync inputs have no effect.
- R8: With `CLK_PER_EN=2`, the environment leaves at least one idle clock between enables. Two multipliers then give results identical to R1, R2 and R4.
- R9: With `CLK_PER_EN=3`, the environment leaves at least two idle clocks between enables. One multiplier then gives results identical to R1, R2 and R4.
- R10: While `rst_n` is low at a clock edge, the frame marker pipeline and all result registers clear, so `sync_out`, `res_sum` and `res_prod` read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Clock enable; the pipeline advances only when high |
| sync_in | input | 1 | Marks the first sample pair of a transform |
| samp_a | input | 2*IN_W | Upper sample {real, imag} |
| samp_b | input | 2*IN_W | Lower sample {real, imag} |
| coef | input | 2*CF_W | Twiddle {real, imag}, unity = 2^(CF_W-2) |
| res_sum | output | 2*OUT_W | Rounded a+b {real, imag} |
| res_prod | output | 2*OUT_W | Rounded (a-b)*c {real, imag} |
| sync_out | output | 1 | High with the results of a marked pair |

## Verification
The bench builds three copies with the default widths 15/20/16. The first uses `CLK_PER_EN=1` and `POST_SHIFT=0`, and is driven with back-to-back and irregular enables. The second uses `CLK_PER_EN=2` with `POST_SHIFT=1`, and the third uses `CLK_PER_EN=3` with `POST_SHIFT=2`. Both of these are fed with idle gaps that meet their spacing rules. The non-zero shifts let odd sums produce exact halves on the sum path. A half-scale twiddle produces exact halves on the product path. Twiddles of one and of the imaginary unit expose the packing, and a reset in the middle of the stream checks the clearing behaviour.

// File: rtl/fft_bfly_pkg.sv
// Shared helpers for the radix-2 butterfly.
// Assumes nothing beyond elaboration-time constant arguments.
package fft_bfly_pkg;

    // Larger of two elaboration-time integers.
    function automatic int imax(input int x, input int y);
        return (x > y) ? x : y;
    endfunction

    // Work step of the single-multiplier sequencer between two enables.
    typedef enum logic [1:0] {
        PH_K1   = 2'd0,
        PH_RE   = 2'd1,
        PH_IDLE = 2'd2
    } mul_phase_e;

endpackage

// File: rtl/fft_bfly_round.sv
// Registered convergent rounder: drops FRAC low bits of a signed value with
// round-half-to-even, then keeps the low OW bits. Updates only when en is high.
// Assumes IW > FRAC when FRAC > 0.
module fft_bfly_round #(
    parameter int IW   = 16,
    parameter int FRAC = 0,
    parameter int OW   = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic signed [IW-1:0] din,
    output logic        [OW-1:0] dout
);
    localparam int EW = fft_bfly_pkg::imax(IW + 1, OW + FRAC + 1);

    logic signed [EW-1:0] ext;
    assign ext = EW'(din);

    generate
        if (FRAC == 0) begin : g_pass
            // Register the value unchanged apart from width.
            always_ff @(posedge clk) begin
                if (!rst_n)  dout <= '0;
                else if (en) dout <= OW'(ext);
            end
        end else begin : g_round
            localparam logic [FRAC-1:0] HALF = FRAC'(1 << (FRAC - 1));
            logic signed [EW-1:0] quo;
            logic                 bump;

            // Integer part and the decision to round it up.
            always_comb begin
                quo  = ext >>> FRAC;
                bump = (din[FRAC-1:0] > HALF) || ((din[FRAC-1:0] == HALF) && quo[0]);
            end

            // Register the rounded value.
            always_ff @(posedge clk) begin
                if (!rst_n)  dout <= '0;
                else if (en) dout <= OW'(quo + EW'(bump));
            end
        end
    endgenerate
endmodule

// File: rtl/fft_bfly_cmul.sv
// Complex multiplier p = d * c in three-product form:
//   k1 = cr*(dr+di), k2 = dr*(ci-cr), k3 = di*(cr+ci); re = k1-k3, im = k1+k2.
// The result registers load on en. CLK_PER_EN (1..3) picks how many physical
// multipliers are built. For 2 and 3, the partial products are formed on the
// idle clocks after an enable. This assumes d and c stay stable from one
// enable to the next and that the enable gap is honoured.
module fft_bfly_cmul #(
    parameter int DW         = 16,
    parameter int CW         = 20,
    parameter int CLK_PER_EN = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic signed [DW-1:0]     d_re,
    input  logic signed [DW-1:0]     d_im,
    input  logic signed [CW-1:0]     c_re,
    input  logic signed [CW-1:0]     c_im,
    output logic signed [DW+CW+2:0]  p_re,
    output logic signed [DW+CW+2:0]  p_im
);
    import fft_bfly_pkg::*;

    localparam int AW = DW + 1;
    localparam int BW = CW + 1;
    localparam int PW = AW + BW;
    localparam int RW = PW + 1;

    logic signed [AW-1:0] d_sum;
    logic signed [BW-1:0] c_sum, c_dif;

    // Pre-adders shared by every variant.
    always_comb begin
        d_sum = AW'(d_re) + AW'(d_im);
        c_sum = BW'(c_re) + BW'(c_im);
        c_dif = BW'(c_im) - BW'(c_re);
    end

    generate
        if (CLK_PER_EN <= 1) begin : g_three
            logic signed [PW-1:0] k1, k2, k3;

            // Three products in parallel.
            always_comb begin
                k1 = PW'(d_sum) * PW'(c_re);
                k2 = PW'(d_re)  * PW'(c_dif);
                k3 = PW'(d_im)  * PW'(c_sum);
            end

            // Load both result parts on every enable.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    p_re <= '0;
                    p_im <= '0;
                end else if (en) begin
                    p_re <= RW'(k1) - RW'(k3);
                    p_im <= RW'(k1) + RW'(k2);
                end
            end
        end else if (CLK_PER_EN == 2) begin : g_two
            logic signed [AW-1:0] opa;
            logic signed [BW-1:0] opb;
            logic signed [PW-1:0] m0, m1, k1_r;
            logic signed [RW-1:0] re_r;
            logic                 first_idle;

            // Multiplier 0 forms k2 on the enable clock and k1 otherwise;
            // multiplier 1 always forms k3.
            always_comb begin
                opa = en ? AW'(d_re) : d_sum;
                opb = en ? c_dif     : BW'(c_re);
                m0  = PW'(opa) * PW'(opb);
                m1  = PW'(d_im) * PW'(c_sum);
            end

            // Real part and k1 on the first idle clock; finish on the enable.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    first_idle <= 1'b0;
                    k1_r       <= '0;
                    re_r       <= '0;
                    p_re       <= '0;
                    p_im       <= '0;
                end else if (en) begin
                    first_idle <= 1'b1;
                    p_re       <= re_r;
                    p_im       <= RW'(k1_r) + RW'(m0);
                end else begin
                    first_idle <= 1'b0;
                    if (first_idle) begin
                        k1_r <= m0;
                        re_r <= RW'(m0) - RW'(m1);
                    end
                end
            end
        end else begin : g_one
            logic signed [AW-1:0] opa;
            logic signed [BW-1:0] opb;
            logic signed [PW-1:0] m, k1_r;
            logic signed [RW-1:0] re_r;
            mul_phase_e           ph;

            // One multiplier; operands chosen by the step.
            always_comb begin
                if (en) begin
                    opa = AW'(d_re);
                    opb = c_dif;
                end else if (ph == PH_RE) begin
                    opa = AW'(d_im);
                    opb = c_sum;
                end else begin
                    opa = d_sum;
                    opb = BW'(c_re);
                end
                m = PW'(opa) * PW'(opb);
            end

            // k1 on idle 1, real part on idle 2, imaginary on the enable.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ph   <= PH_IDLE;
                    k1_r <= '0;
                    re_r <= '0;
                    p_re <= '0;
                    p_im <= '0;
                end else if (en) begin
                    ph   <= PH_K1;
                    p_re <= re_r;
                    p_im <= RW'(k1_r) + RW'(m);
                end else begin
                    case (ph)
                        PH_K1: begin
                            k1_r <= m;
                            ph   <= PH_RE;
                        end
                        PH_RE: begin
                            re_r <= RW'(k1_r) - RW'(m);
                            ph   <= PH_IDLE;
                        end
                        default: ph <= PH_IDLE;
                    endcase
                end
            end
        end
    endgenerate

    // Direct four-product reference used only by the checks below.
    logic signed [RW-1:0] full_re, full_im;
    always_comb begin
        full_re = RW'(PW'(d_re) * PW'(c_re)) - RW'(PW'(d_im) * PW'(c_im));
        full_im = RW'(PW'(d_re) * PW'(c_im)) + RW'(PW'(d_im) * PW'(c_re));
    end

    AST_PROD_RE: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (p_re == $past(full_re)));  // R2
    AST_PROD_IM: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (p_im == $past(full_im)));  // R2

    generate
        if (CLK_PER_EN > 1) begin : g_gap_chk
            logic [1:0] idle_cnt;

            // Idle clocks since the last enable, saturating at 3.
            always_ff @(posedge clk) begin
                if (!rst_n)              idle_cnt <= 2'd3;
                else if (en)             idle_cnt <= 2'd0;
                else if (idle_cnt != 3)  idle_cnt <= idle_cnt + 2'd1;
            end

            AST_EN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
                en |-> (32'(idle_cnt) >= CLK_PER_EN - 1));  // R8, R9
        end
    endgenerate
endmodule

// File: rtl/fft_bfly_r2.sv
// Radix-2 decimation-in-frequency butterfly for a streaming FFT stage.
// Enable 1 registers a+b, a-b, c and the marker. Enable 2 registers the
// complex product and the delayed sum. Enable 3 rounds both to OUT_W.
// The caller must honour the CLK_PER_EN enable spacing (1..3).
module fft_bfly_r2 #(
    parameter int IN_W       = 15,
    parameter int CF_W       = 20,
    parameter int OUT_W      = 16,
    parameter int CLK_PER_EN = 1,
    parameter int POST_SHIFT = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 sync_in,
    input  logic [2*IN_W-1:0]    samp_a,
    input  logic [2*IN_W-1:0]    samp_b,
    input  logic [2*CF_W-1:0]    coef,
    output logic [2*OUT_W-1:0]   res_sum,
    output logic [2*OUT_W-1:0]   res_prod,
    output logic                 sync_out
);
    localparam int DW    = IN_W + 1;
    localparam int RW    = DW + CF_W + 3;
    localparam int PFRAC = CF_W - 2 + POST_SHIFT;

    // Index 0 is the real part, index 1 the imaginary part.
    logic signed [IN_W-1:0] a_part [2];
    logic signed [IN_W-1:0] b_part [2];
    logic signed [DW-1:0]   s1_sum [2];
    logic signed [DW-1:0]   s1_dif [2];
    logic signed [DW-1:0]   s2_sum [2];
    logic signed [CF_W-1:0] s1_cre, s1_cim;
    logic signed [RW-1:0]   prod   [2];
    logic [OUT_W-1:0]       sum_o  [2];
    logic [OUT_W-1:0]       prod_o [2];
    logic                   s1_sync, s2_sync;

    // Unpack {real, imag} samples.
    always_comb begin
        a_part[0] = samp_a[2*IN_W-1:IN_W];
        a_part[1] = samp_a[IN_W-1:0];
        b_part[0] = samp_b[2*IN_W-1:IN_W];
        b_part[1] = samp_b[IN_W-1:0];
    end

    // Enable 1: sum, difference, twiddle and marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 2; k++) begin
                s1_sum[k] <= '0;
                s1_dif[k] <= '0;
            end
            s1_cre  <= '0;
            s1_cim  <= '0;
            s1_sync <= 1'b0;
        end else if (en) begin
            for (int k = 0; k < 2; k++) begin
                s1_sum[k] <= DW'(a_part[k]) + DW'(b_part[k]);
                s1_dif[k] <= DW'(a_part[k]) - DW'(b_part[k]);
            end
            s1_cre  <= coef[2*CF_W-1:CF_W];
            s1_cim  <= coef[CF_W-1:0];
            s1_sync <= sync_in;
        end
    end

    // Enable 2: complex product of the difference and the twiddle.
    fft_bfly_cmul #(
        .DW(DW), .CW(CF_W), .CLK_PER_EN(CLK_PER_EN)
    ) u_cmul (
        .clk(clk), .rst_n(rst_n), .en(en),
        .d_re(s1_dif[0]), .d_im(s1_dif[1]),
        .c_re(s1_cre), .c_im(s1_cim),
        .p_re(prod[0]), .p_im(prod[1])
    );

    // Enable 2: delay the sum and the marker to match the multiplier.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 2; k++) s2_sum[k] <= '0;
            s2_sync <= 1'b0;
        end else if (en) begin
            for (int k = 0; k < 2; k++) s2_sum[k] <= s1_sum[k];
            s2_sync <= s1_sync;
        end
    end

    // Enable 3: round each part of each result.
    generate
        for (genvar k = 0; k < 2; k++) begin : g_part
            fft_bfly_round #(.IW(DW), .FRAC(POST_SHIFT), .OW(OUT_W)) u_rsum (
                .clk(clk), .rst_n(rst_n), .en(en),
                .din(s2_sum[k]), .dout(sum_o[k])
            );
            fft_bfly_round #(.IW(RW), .FRAC(PFRAC), .OW(OUT_W)) u_rprod (
                .clk(clk), .rst_n(rst_n), .en(en),
                .din(prod[k]), .dout(prod_o[k])
            );
        end
    endgenerate

    // Enable 3: marker leaves with its results.
    always_ff @(posedge clk) begin
        if (!rst_n)  sync_out <= 1'b0;
        else if (en) sync_out <= s2_sync;
    end

    assign res_sum  = {sum_o[0], sum_o[1]};
    assign res_prod = {prod_o[0], prod_o[1]};

    AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(res_sum) && $stable(res_prod)));  // R7
    AST_HOLD_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(sync_out));  // R7
endmodule

// File: tb/fft_bfly_r2_test.sv
`timescale 1ns/1ps

// Behavioural reference: a queue of expected results, popped on the third enable.
module fft_bfly_r2_ref #(
    parameter int IN_W = 15,
    parameter int CF_W = 20,
    parameter int OUT_W = 16,
    parameter int SH = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                sync_in,
    input  logic [2*IN_W-1:0]   a,
    input  logic [2*IN_W-1:0]   b,
    input  logic [2*CF_W-1:0]   c,
    output logic [2*OUT_W-1:0]  exp_sum,
    output logic [2*OUT_W-1:0]  exp_prod,
    output logic                exp_sync
);
    typedef struct packed {
        logic [2*OUT_W-1:0] s;
        logic [2*OUT_W-1:0] p;
        logic               y;
    } ent_t;

    ent_t q[$];

    function automatic longint rnd(input longint v, input int f);
        longint qt, r, h;
        if (f == 0) return v;
        qt = v >>> f;
        r  = v - (qt <<< f);
        h  = longint'(1) <<< (f - 1);
        if (r > h || (r == h && qt[0])) qt = qt + 1;
        return qt;
    endfunction

    function automatic ent_t calc(input logic [2*IN_W-1:0] va, vb,
                                  input logic [2*CF_W-1:0] vc, input logic vy);
        ent_t e;
        longint ar, ai, br, bi, cr, ci, dr, di;
        ar = longint'($signed(va[2*IN_W-1:IN_W]));
        ai = longint'($signed(va[IN_W-1:0]));
        br = longint'($signed(vb[2*IN_W-1:IN_W]));
        bi = longint'($signed(vb[IN_W-1:0]));
        cr = longint'($signed(vc[2*CF_W-1:CF_W]));
        ci = longint'($signed(vc[CF_W-1:0]));
        dr = ar - br;
        di = ai - bi;
        e.s = {OUT_W'(rnd(ar + br, SH)), OUT_W'(rnd(ai + bi, SH))};
        e.p = {OUT_W'(rnd(dr * cr - di * ci, CF_W - 2 + SH)),
               OUT_W'(rnd(dr * ci + di * cr, CF_W - 2 + SH))};
        e.y = vy;
        return e;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            exp_sum  <= '0;
            exp_prod <= '0;
            exp_sync <= 1'b0;
        end else if (en) begin
            q.push_back(calc(a, b, c, sync_in));
            if (q.size() == 3) begin
                exp_sum  <= q[0].s;
                exp_prod <= q[0].p;
                exp_sync <= q[0].y;
                void'(q.pop_front());
            end
        end
    end
endmodule

module fft_bfly_r2_test;
    localparam int IW = 15;
    localparam int CW = 20;
    localparam int OW = 16;
    localparam int WD = 100000;
    localparam int UNITY = 1 << (CW - 2);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en1 = 1'b0, ens = 1'b0, sy = 1'b0;
    logic [2*IW-1:0] a = '0, b = '0;
    logic [2*CW-1:0] c = '0;
    logic run_chk = 1'b0;
    logic done = 1'b0;
    string ptag = "R10";
    int n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    logic [2*OW-1:0] s1, p1, s2, p2, s3, p3, es1, ep1, es2, ep2, es3, ep3;
    logic y1, y2, y3, ey1, ey2, ey3;

    fft_bfly_r2 #(.CLK_PER_EN(1), .POST_SHIFT(0)) uut (
        .clk(clk), .rst_n(rst_n), .en(en1), .sync_in(sy), .samp_a(a), .samp_b(b),
        .coef(c), .res_sum(s1), .res_prod(p1), .sync_out(y1));
    fft_bfly_r2 #(.CLK_PER_EN(2), .POST_SHIFT(1)) uut_c2 (
        .clk(clk), .rst_n(rst_n), .en(ens), .sync_in(sy), .samp_a(a), .samp_b(b),
        .coef(c), .res_sum(s2), .res_prod(p2), .sync_out(y2));
    fft_bfly_r2 #(.CLK_PER_EN(3), .POST_SHIFT(2)) uut_c3 (
        .clk(clk), .rst_n(rst_n), .en(ens), .sync_in(sy), .samp_a(a), .samp_b(b),
        .coef(c), .res_sum(s3), .res_prod(p3), .sync_out(y3));

    fft_bfly_r2_ref #(.SH(0)) ref1 (.clk(clk), .rst_n(rst_n), .en(en1), .sync_in(sy),
        .a(a), .b(b), .c(c), .exp_sum(es1), .exp_prod(ep1), .exp_sync(ey1));
    fft_bfly_r2_ref #(.SH(1)) ref2 (.clk(clk), .rst_n(rst_n), .en(ens), .sync_in(sy),
        .a(a), .b(b), .c(c), .exp_sum(es2), .exp_prod(ep2), .exp_sync(ey2));
    fft_bfly_r2_ref #(.SH(2)) ref3 (.clk(clk), .rst_n(rst_n), .en(ens), .sync_in(sy),
        .a(a), .b(b), .c(c), .exp_sum(es3), .exp_prod(ep3), .exp_sync(ey3));

    task automatic chk(input string freq, input string dreq,
                       input logic [2*OW-1:0] act, input logic [2*OW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s (%s, phase %s) t=%0t: actual %h expected %h",
                     freq, dreq, ptag, $time, act, exp);
        end
    endtask

    // Compare every DUT to its model on each falling edge.
    always @(negedge clk) begin
        if (run_chk && !done) begin
            chk("R1 sum",  "R2 ck1", s1, es1);
            chk("R2 prod", "R2 ck1", p1, ep1);
            chk("R6 sync", "R2 ck1", 32'(y1), 32'(ey1));
            chk("R1 sum",  "R8 ck2", s2, es2);
            chk("R2 prod", "R8 ck2", p2, ep2);
            chk("R6 sync", "R8 ck2", 32'(y2), 32'(ey2));
            chk("R1 sum",  "R9 ck3", s3, es3);
            chk("R2 prod", "R9 ck3", p3, ep3);
            chk("R6 sync", "R9 ck3", 32'(y3), 32'(ey3));
        end
    end

    function automatic logic [2*IW-1:0] pk(input int re, input int im);
        return {IW'(re), IW'(im)};
    endfunction
    function automatic logic [2*CW-1:0] cpk(input int re, input int im);
        return {CW'(re), CW'(im)};
    endfunction
    function automatic logic [2*IW-1:0] r30();
        return (2*IW)'($urandom);
    endfunction
    function automatic logic [2*CW-1:0] r40();
        return (2*CW)'({$urandom, $urandom});
    endfunction

    task automatic summary();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic cyc(input logic e1, input logic es, input logic [2*IW-1:0] va,
                       input logic [2*IW-1:0] vb, input logic [2*CW-1:0] vc, input logic vs);
        @(negedge clk);
        en1 = e1; ens = es; a = va; b = vb; c = vc; sy = vs;
    endtask

    // One enable on all DUTs, then gap idle clocks with random inputs (R7).
    task automatic slow(input logic [2*IW-1:0] va, input logic [2*IW-1:0] vb,
                        input logic [2*CW-1:0] vc, input logic vs, input int gap);
        cyc(1'b1, 1'b1, va, vb, vc, vs);
        for (int i = 0; i < gap; i++) cyc(1'b0, 1'b0, r30(), r30(), r40(), 1'($urandom));
    endtask

    initial begin
        repeat (WD) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R5 watchdog: actual %0d cycles, expected fewer", WD);
            summary();
        end
    end

    initial begin
        // R10: reset state.
        repeat (2) @(negedge clk);
        run_chk = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        // R5: a marked pair through unity twiddle, then its latency.
        ptag = "R5";
        slow(pk(100, -20), pk(30, 7), cpk(UNITY, 0), 1'b1, 2);
        // R3: imaginary-unit twiddle swaps and negates the parts.
        ptag = "R3";
        slow(pk(50, 9), pk(10, -4), cpk(0, UNITY), 1'b0, 2);
        slow(pk(-700, 321), pk(44, 45), cpk(UNITY, 0), 1'b0, 3);
        // R4: exact halves on both paths with a half-scale twiddle.
        ptag = "R4";
        slow(pk(3, -5), pk(0, 0), cpk(UNITY / 2, 0), 1'b0, 2);
        slow(pk(5, 7), pk(0, 0), cpk(UNITY / 2, 0), 1'b0, 2);
        slow(pk(1, 3), pk(0, 0), cpk(UNITY / 2, 0), 1'b0, 2);
        slow(pk(-1, 6), pk(0, 0), cpk(UNITY / 4, 0), 1'b0, 2);
        for (int i = 0; i < 3; i++) slow('0, '0, '0, 1'b0, 2);

        // R8 and R9: random data with legal gaps for the shared multipliers.
        ptag = "R8";
        for (int i = 0; i < 300; i++)
            slow(r30(), r30(), r40(), ($urandom % 6) == 0, 2 + ($urandom % 3));
        ptag = "R9";
        for (int i = 0; i < 100; i++)
            slow(r30(), r30(), r40(), ($urandom % 3) == 0, 2);

        // R1: back-to-back enables on the single-cycle copy.
        ptag = "R1";
        for (int i = 0; i < 400; i++)
            cyc(1'b1, 1'b0, r30(), r30(), r40(), ($urandom % 8) == 0);
        // R6: consecutive marked pairs.
        ptag = "R6";
        for (int i = 0; i < 12; i++)
            cyc(1'b1, 1'b0, r30(), r30(), r40(), (i % 3) != 1);
        // R7: irregular enables; inputs change while idle.
        ptag = "R7";
        for (int i = 0; i < 400; i++)
            cyc(1'($urandom), 1'b0, r30(), r30(), r40(), 1'($urandom));

        // R10: reset in the middle of a stream.
        ptag = "R10";
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, r30(), r30(), r40(), 1'b1);
        @(negedge clk);
        rst_n = 1'b1;
        en1 = 1'b0;
        for (int i = 0; i < 30; i++)
            cyc(1'b1, 1'b0, r30(), r30(), r40(), ($urandom % 4) == 0);
        for (int i = 0; i < 10; i++)
            slow(r30(), r30(), r40(), ($urandom % 2) == 0, 2);

        repeat (3) @(negedge clk);
        summary();
    end
endmodule